// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a 32-bit processor core in which every instruction completes in one clock cycle. It supports register add and subtract, OR with a zero-extended immediate, word load, word store, and branch-if-equal. The core holds the program counter and a 32-entry register file with two combinational read ports and one clocked write port. It also contains an ALU, an immediate extender, and the multiplexers that choose the ALU operand, the destination register, the write-back value and the next program counter.

Two memories sit outside the core. The instruction memory is read combinationally at `imem_addr`. The data memory is also read combinationally, and it writes on the rising clock edge when `dmem_we` is high. Each cycle the decoder turns the opcode and funct fields into one instruction kind. The next-PC selector then has two named choices: `NPC_SEQ`, which steps to PC+4, and `NPC_BRANCH`, which goes to the branch target. Every cycle moves to exactly one of them.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC (`imem_addr`) to 0 on the next clock edge. While `rst` is high, neither the register file nor the data memory is written.
- R2: ADDU (op 0x00, funct 0x21, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11) writes R[rs]+R[rt] to R[rd]. The sum wraps modulo 2^32 and never traps.
- R3: SUBU (op 0x00, funct 0x23) writes R[rs]-R[rt] to R[rd]. The difference wraps modulo 2^32.
- R4: ORI (op 0x0D, imm16 in bits 15:0) writes R[rs] OR the zero-extended immediate to R[rt].
- R5: LW (op 0x23) drives `dmem_addr` = R[rs] + sign-extended imm16 and writes `dmem_rdata` to R[rt].
- R6: SW (op 0x2B) drives that same address, drives `dmem_wdata` = R[rt] and raises `dmem_we`. It writes no register.
- R7: BEQ (op 0x04) with R[rs]==R[rt] sets the next PC to PC+4+(sign-extended imm16 shifted left by 2). A negative offset branches backward.
- R8: BEQ with unequal operands, and every other instruction, sets the next PC to PC+4.
- R9: Register 0 always reads as zero. Writes to it are ignored.
- R10: An unknown opcode, or an R-type word with an unknown funct, writes no register and no memory, and still advances the PC by 4.
- R11: `dmem_we` is high only during a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register, PC and data memory writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
The register file cannot be seen from the ports, so its contents are hard to check directly. Every register result is therefore brought out by a later store, and the bench reads the word back from its own data memory model. The same approach shows that a write is ignored: an illegal word that names r1, an illegal funct, and writes aimed at r0 are each followed by a store of the register they could have changed. Branch behaviour is tracked by sampling `imem_addr` after a counted number of edges. This distinguishes a taken branch, a not-taken branch and a skipped block, and the backward case is covered by the self-loop that ends each program.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU   = 6'h21;
    localparam logic [5:0] FN_SUBU   = 6'h23;

    typedef enum logic [2:0] {
        K_NOP, K_ADDU, K_SUBU, K_ORI, K_LW, K_SW, K_BEQ
    } op_kind_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_OR
    } alu_op_e;

    typedef enum logic {
        NPC_SEQ, NPC_BRANCH
    } npc_sel_e;

    typedef struct packed {
        op_kind_e kind;
        alu_op_e  alu;
        logic     reg_we;
        logic     dst_rd;
        logic     src_imm;
        logic     imm_sign;
        logic     mem_to_reg;
        logic     mem_we;
        logic     is_branch;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl      = '0;
        ctrl.kind = K_NOP;
        ctrl.alu  = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                unique case (funct)
                    FN_ADDU: begin
                        ctrl.kind   = K_ADDU;
                        ctrl.reg_we = 1'b1;
                        ctrl.dst_rd = 1'b1;
                    end
                    FN_SUBU: begin
                        ctrl.kind   = K_SUBU;
                        ctrl.alu    = ALU_SUB;
                        ctrl.reg_we = 1'b1;
                        ctrl.dst_rd = 1'b1;
                    end
                    default: ctrl.kind = K_NOP;
                endcase
            end
            OPC_ORI: begin
                ctrl.kind    = K_ORI;
                ctrl.alu     = ALU_OR;
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.kind       = K_LW;
                ctrl.reg_we     = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.imm_sign   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_SW: begin
                ctrl.kind     = K_SW;
                ctrl.src_imm  = 1'b1;
                ctrl.imm_sign = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.kind      = K_BEQ;
                ctrl.alu       = ALU_SUB;
                ctrl.is_branch = 1'b1;
            end
            default: ctrl.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R2: a committed write is visible on the read port one cycle later
    p_write_commits_r2: assert property (@(posedge clk)
        (we && (wa != '0)) |=> ((ra_a != $past(wa)) || (rd_a == $past(wd))));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    logic [XLEN-1:0]   pc, pc_plus4, br_target, pc_next;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd, wa;
    logic [IMMW-1:0]   f_imm;
    logic [XLEN-1:0]   simm, zimm, ext, alu_b, alu_y, wb;
    logic [XLEN-1:0]   rd_a, rd_b;
    logic              alu_zero, reg_we;
    ctrl_t             ctrl;
    npc_sel_e          npc_sel;

    assign f_rs  = imem_data[25:21];
    assign f_rt  = imem_data[20:16];
    assign f_rd  = imem_data[15:11];
    assign f_imm = imem_data[IMMW-1:0];

    sc_decode u_dec (
        .opcode (imem_data[31:26]),
        .funct  (imem_data[5:0]),
        .ctrl   (ctrl)
    );

    assign simm  = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
    assign zimm  = {{(XLEN-IMMW){1'b0}}, f_imm};
    assign ext   = ctrl.imm_sign ? simm : zimm;
    assign wa    = ctrl.dst_rd ? f_rd : f_rt;
    assign reg_we = ctrl.reg_we & ~rst;

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk  (clk),
        .we   (reg_we),
        .wa   (wa),
        .wd   (wb),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (rd_a),
        .rd_b (rd_b)
    );

    assign alu_b = ctrl.src_imm ? ext : rd_b;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .op   (ctrl.alu),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb         = ctrl.mem_to_reg ? dmem_rdata : alu_y;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rd_b;
    assign dmem_we    = ctrl.mem_we & ~rst;

    // next-PC selection: SEQ or BRANCH each cycle
    assign npc_sel   = (ctrl.is_branch && alu_zero) ? NPC_BRANCH : NPC_SEQ;
    assign pc_plus4  = pc + XLEN'(4);
    assign br_target = pc_plus4 + {simm[XLEN-3:0], 2'b00};

    always_comb begin
        unique case (npc_sel)
            NPC_SEQ:    pc_next = pc_plus4;
            NPC_BRANCH: pc_next = br_target;
            default:    pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    assign imem_addr = pc;

    p_pc_reset_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0));

    p_no_write_in_reset_r1: assert property (@(posedge clk)
        rst |-> (!dmem_we && !reg_we));

    p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.is_branch && (rd_a == rd_b)) |=> (pc == $past(pc) + XLEN'(4)));

    p_taken_target_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_branch && (rd_a == rd_b)) |=>
            (pc == $past(pc) + XLEN'(4) + ($past(simm) << 2)));

    p_store_only_r11: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> ((ctrl.kind == K_SW) && !reg_we));

    p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_NOP) |-> (!reg_we && !dmem_we));
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

    always #10 clk = ~clk;

    sc_core u_sc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        imem[0] = enc_i(6'h2B, 0, 0, 16'h0);
        imem[1] = enc_i(6'h0D, 0, 1, 16'h1);
        imem[2] = enc_i(6'h0D, 0, 2, 16'h2);
        imem[3] = enc_i(6'h0D, 0, 3, 16'h3);
        imem[4] = HALT;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'h0);
        chk("R1 no store in reset", {31'h0, dmem_we}, 32'h0);
        rst = 1'b0;
        step(3);
        chk("R8 pc after 3 steps", imem_addr, 32'd12);
        rst = 1'b1;
        step(1);
        chk("R1 mid-run reset", imem_addr, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_alu();
        clear_mem();
        imem[0]  = enc_i(6'h0D, 0, 1, 16'h1234);
        imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
        imem[2]  = enc_r(1, 2, 3, 6'h21);
        imem[3]  = enc_r(1, 2, 4, 6'h23);
        imem[4]  = enc_i(6'h0D, 0, 7, 16'h1);
        imem[5]  = enc_r(0, 7, 6, 6'h23);
        imem[6]  = enc_r(6, 7, 8, 6'h21);
        imem[7]  = enc_i(6'h2B, 0, 3, 16'd0);
        imem[8]  = enc_i(6'h2B, 0, 4, 16'd4);
        imem[9]  = enc_i(6'h2B, 0, 2, 16'd8);
        imem[10] = enc_i(6'h2B, 0, 8, 16'd12);
        imem[11] = enc_i(6'h2B, 0, 6, 16'd16);
        imem[12] = HALT;
        do_reset();
        step(20);
        chk("R2 addu", dmem[0], 32'h0001_1233);
        chk("R3 subu wrap", dmem[1], 32'hFFFF_1235);
        chk("R4 ori zero-extend", dmem[2], 32'h0000_FFFF);
        chk("R2 addu wrap", dmem[3], 32'h0);
        chk("R3 subu 0-1", dmem[4], 32'hFFFF_FFFF);
        chk("R7 halt self-loop", imem_addr, 32'd48);
    endtask

    task automatic t_mem();
        clear_mem();
        dmem[10] = 32'hCAFE_BABE;
        imem[0] = enc_i(6'h0D, 0, 1, 16'h0030);
        imem[1] = enc_i(6'h23, 1, 2, 16'hFFF8);
        imem[2] = enc_i(6'h2B, 1, 2, 16'd4);
        imem[3] = enc_i(6'h0D, 0, 4, 16'h8000);
        imem[4] = enc_i(6'h2B, 0, 4, 16'd56);
        imem[5] = enc_i(6'h2B, 0, 2, 16'd60);
        imem[6] = HALT;
        do_reset();
        step(1);
        chk("R5 lw address", dmem_addr, 32'd40);
        chk("R11 no we on lw", {31'h0, dmem_we}, 32'h0);
        step(1);
        chk("R6 sw we", {31'h0, dmem_we}, 32'h1);
        chk("R6 sw address", dmem_addr, 32'd52);
        chk("R6 sw data", dmem_wdata, 32'hCAFE_BABE);
        step(10);
        chk("R5 lw result", dmem[13], 32'hCAFE_BABE);
        chk("R4 ori 0x8000", dmem[14], 32'h0000_8000);
        chk("R6 sw leaves rt", dmem[15], 32'hCAFE_BABE);
    endtask

    task automatic t_branch();
        clear_mem();
        imem[0]  = enc_i(6'h0D, 0, 1, 16'd5);
        imem[1]  = enc_i(6'h0D, 0, 2, 16'd5);
        imem[2]  = enc_i(6'h0D, 0, 3, 16'd7);
        imem[3]  = enc_i(6'h04, 1, 3, 16'd2);
        imem[4]  = enc_i(6'h0D, 0, 4, 16'h00AA);
        imem[5]  = enc_i(6'h04, 1, 2, 16'd2);
        imem[6]  = enc_i(6'h0D, 0, 4, 16'h00BB);
        imem[7]  = enc_i(6'h0D, 0, 5, 16'h00CC);
        imem[8]  = enc_i(6'h2B, 0, 4, 16'd0);
        imem[9]  = enc_i(6'h04, 0, 0, 16'd2);
        imem[10] = enc_i(6'h0D, 0, 6, 16'h0099);
        imem[11] = enc_i(6'h2B, 0, 6, 16'd8);
        imem[12] = enc_i(6'h0D, 0, 6, 16'd1);
        imem[13] = enc_i(6'h2B, 0, 6, 16'd4);
        imem[14] = HALT;
        do_reset();
        step(6);
        chk("R7 beq taken target", imem_addr, 32'd32);
        step(2);
        chk("R7 beq r0,r0 target", imem_addr, 32'd48);
        step(8);
        chk("R8 beq not taken falls through", dmem[0], 32'h0000_00AA);
        chk("R7 skipped store", dmem[2], 32'h0);
        chk("R7 landing code ran", dmem[1], 32'h1);
        chk("R7 backward self-loop", imem_addr, 32'd56);
    endtask

    task automatic t_r0_illegal();
        clear_mem();
        dmem[0]  = 32'hDEAD_0000;
        dmem[1]  = 32'hDEAD_0001;
        dmem[20] = 32'h5A5A_5A5A;
        imem[0] = enc_i(6'h0D, 0, 1, 16'd3);
        imem[1] = enc_i(6'h0D, 0, 0, 16'h0055);
        imem[2] = enc_r(1, 1, 0, 6'h21);
        imem[3] = enc_i(6'h2B, 0, 0, 16'd0);
        imem[4] = enc_i(6'h3F, 0, 1, 16'd80);
        imem[5] = enc_r(0, 0, 1, 6'h20);
        imem[6] = enc_i(6'h2B, 0, 1, 16'd4);
        imem[7] = HALT;
        do_reset();
        step(4);
        chk("R10 illegal op no we", {31'h0, dmem_we}, 32'h0);
        step(8);
        chk("R9 r0 stays zero", dmem[0], 32'h0);
        chk("R10 illegal ops leave r1", dmem[1], 32'h3);
        chk("R11 untouched word", dmem[20], 32'h5A5A_5A5A);
        chk("R10 pc advanced past illegal", imem_addr, 32'd28);
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_alu();
        t_mem();
        t_branch();
        t_r0_illegal();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule